// File: doc/BRIEF.md
# Marker-Byte Zero-Run Expander

This block restores a configuration byte stream in which single marker bytes stand in for runs of zero bytes. Three marker values are programmable. A long marker expands to eight 0x00 bytes, a medium marker to four and a short marker to two. Bytes arrive through a valid/ready input port. The expanded stream leaves through a valid/ready output port, one byte per handshake, and the port honours backpressure.

A global compression flag turns expansion on or off. When the flag is clear, every byte passes through unchanged. A marker set to 0xFF is disabled and never expands. When two marker slots hold the same value, the slot with the longer run wins. The output sits behind one register stage. While a run is being sent out, the input port stays closed.

Top module: `zrun_expander`

## Requirements
- R1: While reset is held and on the first cycle after it, `outValid` is 0 and `inReady` is 1.
- R2: With `cfgCompress` = 0, each accepted byte appears once, unchanged, on `outData`, including bytes equal to a marker value.
- R3: With `cfgCompress` = 1, an accepted byte equal to an enabled `cfgMarkLong` produces exactly eight output bytes of 0x00.
- R4: With `cfgCompress` = 1, an accepted byte equal to an enabled `cfgMarkMid` (and not to an enabled `cfgMarkLong`) produces exactly four 0x00 bytes.
- R5: With `cfgCompress` = 1, an accepted byte equal to an enabled `cfgMarkShort` (and to no longer enabled marker) produces exactly two 0x00 bytes.
- R6: A marker field holding 0xFF is disabled, so an input byte of 0xFF never matches it and passes through as one 0xFF byte.
- R7: A byte that matches no enabled marker is output once, unchanged. It is valid on `outData` in the cycle after the edge that accepted it.
- R8: After a marker that starts a run of more than one byte is accepted, `inReady` is 0 until the last zero of that run is on the output.
- R9: While `outValid` = 1 and `outReady` = 0, `outValid` stays 1 and `outData` stays unchanged on the next cycle.
- R10: When several enabled marker fields hold the same value, a matching byte expands to the longest of their runs.
- R11: With `outReady` held at 1 and no run in progress, `inReady` stays 1, so pass-through bytes flow at one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgCompress | input | 1 | Enables marker expansion |
| cfgMarkLong | input | 8 | Marker for a run of eight zeros (0xFF = disabled) |
| cfgMarkMid | input | 8 | Marker for a run of four zeros (0xFF = disabled) |
| cfgMarkShort | input | 8 | Marker for a run of two zeros (0xFF = disabled) |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte |
| inReady | output | 1 | Block accepts the input byte this cycle |
| outValid | output | 1 | Output byte valid |
| outData | output | 8 | Output byte |
| outReady | input | 1 | Consumer accepts the output byte this cycle |

## Verification
The hardest condition to reach is backpressure in the middle of a zero run. In that state the run counter, the held output byte and the closed input port all have to stay frozen together. The bench gets there by dropping `outReady` before it sends a medium marker, so the first zero stalls in the output register. It checks that the byte is held and that the input stays closed, and only then releases the consumer and counts the remaining zeros. Duplicate marker values are set up from the vector table to exercise the run-length priority.

// File: rtl/zrun_pkg.sv
package zrun_pkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic acceptByte;  // an input byte is taken this cycle
    logic zeroFill;    // the taken byte is a marker: load a zero
  } zrunStrobe_t;
endpackage

// File: rtl/zrun_datapath.sv
module zrun_datapath
  import zrun_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_MARK = 3,
  parameter int LONG_RUN = 8,
  localparam int CNT_W   = $clog2(LONG_RUN + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfgCompress,
  input  logic [NUM_MARK-1:0][DATA_W-1:0]   markers,
  input  logic [DATA_W-1:0]                 inData,
  input  zrunStrobe_t                       strobe,
  output logic [CNT_W-1:0]                  runLen,
  output logic [DATA_W-1:0]                 outData
);
  localparam logic [DATA_W-1:0] UNUSED_MARK = '1;

  logic [NUM_MARK-1:0] hit;

  // One comparator per marker slot; slot 0 holds the longest run
  for (genvar i = 0; i < NUM_MARK; i++) begin : g_match
    assign hit[i] = (markers[i] != UNUSED_MARK) && (inData == markers[i]);
  end

  // Walk from the shortest slot to the longest so the longest run wins
  always_comb begin
    runLen = '0;
    for (int i = NUM_MARK - 1; i >= 0; i--) begin
      if (cfgCompress && hit[i]) runLen = CNT_W'(LONG_RUN >> i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outData <= '0;
    end else if (strobe.acceptByte) begin
      outData <= strobe.zeroFill ? '0 : inData;
    end
  end
endmodule

// File: rtl/zrun_ctrl.sv
module zrun_ctrl
  import zrun_pkg::*;
#(
  parameter int LONG_RUN = 8,
  localparam int CNT_W   = $clog2(LONG_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             outReady,
  input  logic [CNT_W-1:0] runLen,
  output logic             inReady,
  output logic             outValid,
  output logic             runBusy,
  output zrunStrobe_t      strobe
);
  logic [CNT_W-1:0] runLeft;   // zeros still owed after the current output byte
  logic             outFree;
  logic             accept;

  assign runBusy = (runLeft != '0);
  assign outFree = !outValid || outReady;
  assign inReady = !runBusy && outFree;
  assign accept  = inValid && inReady;

  assign strobe.acceptByte = accept;
  assign strobe.zeroFill   = (runLen != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      runLeft  <= '0;
    end else if (accept) begin
      outValid <= 1'b1;
      runLeft  <= (runLen == '0) ? '0 : runLen - 1'b1;
    end else if (outValid && outReady) begin
      if (runBusy) runLeft <= runLeft - 1'b1;
      else         outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/zrun_expander.sv
module zrun_expander
  import zrun_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LONG_RUN = 8,
  localparam int NUM_MARK = 3,
  localparam int CNT_W    = $clog2(LONG_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgCompress,
  input  logic [DATA_W-1:0] cfgMarkLong,
  input  logic [DATA_W-1:0] cfgMarkMid,
  input  logic [DATA_W-1:0] cfgMarkShort,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);
  zrunStrobe_t                     strobe;
  logic [CNT_W-1:0]                runLen;
  logic                            runBusy;
  logic [NUM_MARK-1:0][DATA_W-1:0] markers;

  assign markers = {cfgMarkShort, cfgMarkMid, cfgMarkLong};

  zrun_ctrl #(.LONG_RUN(LONG_RUN)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .runLen(runLen), .inReady(inReady), .outValid(outValid),
    .runBusy(runBusy), .strobe(strobe)
  );

  zrun_datapath #(.DATA_W(DATA_W), .NUM_MARK(NUM_MARK), .LONG_RUN(LONG_RUN)) i_dp (
    .clk(clk), .rst_n(rst_n), .cfgCompress(cfgCompress), .markers(markers),
    .inData(inData), .strobe(strobe), .runLen(runLen), .outData(outData)
  );
endmodule

// File: rtl/zrun_checker.sv
module zrun_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgCompress,
  input logic [DATA_W-1:0] cfgMarkLong,
  input logic [DATA_W-1:0] cfgMarkMid,
  input logic [DATA_W-1:0] cfgMarkShort,
  input logic              inValid,
  input logic [DATA_W-1:0] inData,
  input logic              inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady
);
  localparam logic [DATA_W-1:0] OFF = '1;
  logic takeIn;
  logic longHit;
  assign takeIn  = inValid && inReady;
  assign longHit = cfgCompress && (cfgMarkLong != OFF) && (inData == cfgMarkLong);

  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !outValid);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIn && !cfgCompress) |=> (outValid && outData == $past(inData)));

  assert_long_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIn && longHit) |=> (outValid && outData == '0));

  assert_ff_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIn && inData == OFF) |=> (outValid && outData == OFF));

  assert_run_closes_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIn && longHit) |=> !inReady);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

bind zrun_expander zrun_checker #(.DATA_W(DATA_W)) i_zrun_checker (
  .clk(clk), .rst_n(rst_n), .cfgCompress(cfgCompress),
  .cfgMarkLong(cfgMarkLong), .cfgMarkMid(cfgMarkMid), .cfgMarkShort(cfgMarkShort),
  .inValid(inValid), .inData(inData), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady)
);

// File: tb/test_zrun_expander.sv
module test_zrun_expander;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgCompress = 1'b0;
  logic [7:0] cfgMarkLong = 8'hA1, cfgMarkMid = 8'hB2, cfgMarkShort = 8'hC3;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inReady, outValid, outReady = 1'b1;
  logic [7:0] outData;
  int         nRun = 0, nFail = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  zrun_expander i_zrun_expander (
    .clk(clk), .rst_n(rst_n), .cfgCompress(cfgCompress),
    .cfgMarkLong(cfgMarkLong), .cfgMarkMid(cfgMarkMid), .cfgMarkShort(cfgMarkShort),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );

  // {req[3:0], compress, long, mid, short, in, expCount[3:0], expVal}
  localparam int NVEC = 11;
  localparam logic [48:0] VEC [NVEC] = '{
    {4'd2,  1'b0, 8'hA1, 8'hB2, 8'hC3, 8'hA1, 4'd1, 8'hA1}, // R2 marker ignored when off
    {4'd2,  1'b0, 8'hA1, 8'hB2, 8'hC3, 8'hC3, 4'd1, 8'hC3}, // R2
    {4'd3,  1'b1, 8'hA1, 8'hB2, 8'hC3, 8'hA1, 4'd8, 8'h00}, // R3
    {4'd4,  1'b1, 8'hA1, 8'hB2, 8'hC3, 8'hB2, 4'd4, 8'h00}, // R4
    {4'd5,  1'b1, 8'hA1, 8'hB2, 8'hC3, 8'hC3, 4'd2, 8'h00}, // R5
    {4'd7,  1'b1, 8'hA1, 8'hB2, 8'hC3, 8'h5A, 4'd1, 8'h5A}, // R7
    {4'd6,  1'b1, 8'hFF, 8'hB2, 8'hC3, 8'hFF, 4'd1, 8'hFF}, // R6
    {4'd6,  1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 4'd1, 8'hFF}, // R6
    {4'd10, 1'b1, 8'h77, 8'h77, 8'h77, 8'h77, 4'd8, 8'h00}, // R10
    {4'd10, 1'b1, 8'h11, 8'h33, 8'h33, 8'h33, 4'd4, 8'h00}, // R10
    {4'd7,  1'b1, 8'hA1, 8'hB2, 8'hC3, 8'h00, 4'd1, 8'h00}  // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Send one byte, then count output bytes while outReady is high
  task automatic sendAndCollect(input logic [7:0] b, input logic [7:0] expVal,
                                output int cnt, output bit allOk);
    @(negedge clk);
    inData = b; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk); #1 inValid = 1'b0;
    cnt = 0; allOk = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!outValid) break;
      cnt++;
      if (outData != expVal) allOk = 0;
    end
  endtask

  initial begin
    int  cnt;
    bit  ok;
    logic [7:0] seq [4] = '{8'h10, 8'h21, 8'h32, 8'h43};

    repeat (3) @(negedge clk);
    check(!outValid && inReady, "R1", {outValid, inReady}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!outValid && inReady, "R1", {outValid, inReady}, 2'b01);

    for (int v = 0; v < NVEC; v++) begin
      cfgCompress  = VEC[v][44];
      cfgMarkLong  = VEC[v][43:36];
      cfgMarkMid   = VEC[v][35:28];
      cfgMarkShort = VEC[v][27:20];
      sendAndCollect(VEC[v][19:12], VEC[v][7:0], cnt, ok);
      check(cnt == int'(VEC[v][11:8]), $sformatf("R%0d count", VEC[v][48:45]),
            cnt, VEC[v][11:8]);
      check(ok, $sformatf("R%0d value", VEC[v][48:45]), ok, 1);
    end

    // R8: input closed during a long run
    cfgCompress = 1; cfgMarkLong = 8'hA1; cfgMarkMid = 8'hB2; cfgMarkShort = 8'hC3;
    @(negedge clk); inData = 8'hA1; inValid = 1'b1;
    @(posedge clk); #1 inValid = 1'b0;
    @(negedge clk);
    check(!inReady && outValid, "R8", {inReady, outValid}, 2'b01);
    repeat (6) @(negedge clk);
    check(!inReady, "R8 late", inReady, 0);
    @(negedge clk);
    check(inReady && outValid && outData == 8'h00, "R8 end", {inReady, outValid}, 2'b11);
    @(negedge clk);
    check(!outValid, "R3 run ends", outValid, 0);

    // R9: stall on a pass-through byte
    outReady = 1'b0;
    @(negedge clk); inData = 8'h5A; inValid = 1'b1;
    @(posedge clk); #1 inValid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(outValid && outData == 8'h5A && !inReady, "R9", outData, 8'h5A);
    end
    outReady = 1'b1;
    @(negedge clk);
    check(!outValid, "R9 release", outValid, 0);

    // R9 + R4: stall at the start of a medium run
    outReady = 1'b0;
    @(negedge clk); inData = 8'hB2; inValid = 1'b1;
    @(posedge clk); #1 inValid = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check(outValid && outData == 8'h00 && !inReady, "R9 run", outData, 0);
    end
    outReady = 1'b1;
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      if (outValid) cnt++;
      @(negedge clk);
    end
    check(cnt == 4, "R4 after stall", cnt, 4);

    // R11: back-to-back pass-through at full rate
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      if (i > 0) check(outValid && outData == seq[i-1], "R11 data", outData, seq[i-1]);
      if (i < 4) begin
        check(inReady, "R11 ready", inReady, 1);
        inData = seq[i]; inValid = 1'b1;
      end else begin
        inValid = 1'b0;
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule